// File: doc/BRIEF.md
# Halted-Core Debug Command Port

This block is the serial front end of a debug controller for a processor that has been stopped in a debug state. A host drives a serial clock and a data line. The block collects the incoming bits into 16-bit words and groups those words into commands. A command is one operation word followed by zero, one or two extension words, and the operation word sets how many follow. The command is carried out on a small register model as soon as its last word has arrived. That model is a 32-bit entry-cause register and a 32-bit program counter.

Results come back one step late. A read's 32-bit value goes into the output shifter and reaches the host in two 16-bit pieces while the host sends its next two words. Each frame on the line is 17 bits: a status bit followed by the 16 data bits. Status 1 with data 0x0000 means nothing is ready.

When the core enters debug mode, the entry-cause register is loaded with a code that tells the host why. The first command after entry must be a register read. Any other first command raises a sticky sequence-error flag. A resume command makes the port idle until the next entry.

Top module: `dbg_cmd_port`

## Requirements
- R1: Each frame is 17 bits, MSB first. The host samples `dbg_sdo` before each rising edge of `dbg_sclk`. The port samples `dbg_sdi` on that rising edge and advances `dbg_sdo` on the falling edge. The first bit received in a frame is a status slot and is discarded. The remaining 16 bits form the data word.
- R2: Bits 15:14 of the operation word give the number of extension words: 0 gives none, 1 gives one, and 2 or 3 give two. A command executes on the frame that carries its last word.
- R3: Bits 13:12 of the operation word select the command: 0 is a register read, 1 is a register write, 2 is resume and 3 is no-op. Bits 3:0 select the register: 0 is the entry-cause register and 1 is the program counter. A read returns the upper half of the value, with status 0, in the frame that follows the command. It returns the lower half in the frame after that.
- R4: Whenever no result is pending, the outgoing frame is status 1 with data 0x0000.
- R5: On entry (`entry_req` high for one clock), the entry-cause register is set from `entry_src`. A hardware breakpoint (0) gives 0x0000_0000 and a software breakpoint instruction (1) gives 0x0000_0001. The port becomes active.
- R6: A double bus fault (`entry_src` = 2) loads `entry_ssw` into bits 31:16 and 0xFFFF into bits 15:0. For entry sources 0 to 2, the program counter takes `core_pc` with bit 0 cleared.
- R7: A double bus fault during the reset stack/PC fetch (`entry_src` = 3) loads 0xFFFF_FFFF into the program counter and the same fault code into the entry-cause register. No other event leaves the program counter odd.
- R8: If the first command completed after entry is not a register read, `seq_err` is set. It stays set until the next entry, which clears it.
- R9: A register write takes its value from the extension words. With two extension words the value is {first, second}; with one it is that word zero-extended. A write to the program counter clears bit 0.
- R10: A resume command clears `dbg_active`. While the port is inactive, serial clock edges are ignored and `dbg_sdo` stays at 1.
- R11: After reset, `dbg_active` and `seq_err` are 0, `dbg_sdo` is 1 and `pc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_sclk | input | 1 | Debug serial clock from the host, synchronised inside |
| dbg_sdi | input | 1 | Serial data from the host |
| dbg_sdo | output | 1 | Serial data to the host |
| entry_req | input | 1 | One-cycle pulse: the core enters debug mode |
| entry_src | input | 2 | Entry cause: 0 hardware breakpoint, 1 software breakpoint, 2 double fault, 3 double fault in reset fetch |
| entry_ssw | input | 16 | Special status word captured on a double fault |
| core_pc | input | 32 | Program counter of the core at entry |
| dbg_active | output | 1 | Port is in debug mode and accepting commands |
| seq_err | output | 1 | First command after entry was not a register read |
| pc_o | output | 32 | Program counter held by the register model |

## Verification
The bench checks the one-frame lag of results. A design that answered in the same frame, or that put the lower half first, shows shifted or swapped data words. The bench also checks the extension-word count in both its one-word form and its "3 means two" form. A miscounting framer executes an extension word as a new command and returns not-ready where a value is expected. For the fault entries, the bench looks for a lost special status word, a program counter left odd after an ordinary fault, and an all-ones value missing after a reset-fetch fault. It drives serial clocks after resume, which exposes a port that keeps shifting. It sends a no-op as the first command after entry, which exposes a missing or non-clearing sequence flag.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

    typedef enum logic [1:0] {
        K_RDREG = 2'd0,
        K_WRREG = 2'd1,
        K_GO    = 2'd2,
        K_NOP   = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SRC_HWBRK  = 2'd0,
        SRC_SWBRK  = 2'd1,
        SRC_DBLFLT = 2'd2,
        SRC_RSTFLT = 2'd3
    } entry_src_e;

endpackage

// File: rtl/dbg_edge_sync.sv
module dbg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic rise_o,
    output logic fall_o,
    output logic sdi_o
);
    logic [STAGES:0]   clk_pipe_q;
    logic [STAGES-1:0] dat_pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_pipe_q <= '0;
            dat_pipe_q <= '0;
        end else begin
            clk_pipe_q <= {clk_pipe_q[STAGES-1:0], sclk_i};
            dat_pipe_q <= {dat_pipe_q[STAGES-2:0], sdi_i};
        end
    end

    // Edge decided between the last synchronised stage and the one after it.
    assign rise_o = clk_pipe_q[STAGES-1] & ~clk_pipe_q[STAGES];
    assign fall_o = ~clk_pipe_q[STAGES-1] & clk_pipe_q[STAGES];
    assign sdi_o  = dat_pipe_q[STAGES-1];
endmodule

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_port_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] op_i,
    output logic [1:0]        ext_cnt_o,
    output cmd_kind_e         kind_o,
    output logic              sel_cause_o,
    output logic              sel_pc_o
);
    logic [1:0] raw_cnt;
    logic       unused_bits;

    assign raw_cnt     = op_i[WORD_W-1:WORD_W-2];
    assign ext_cnt_o   = (raw_cnt == 2'd3) ? 2'd2 : raw_cnt;
    assign kind_o      = cmd_kind_e'(op_i[WORD_W-3:WORD_W-4]);
    assign sel_cause_o = (op_i[3:0] == 4'd0);
    assign sel_pc_o    = (op_i[3:0] == 4'd1);
    assign unused_bits = ^op_i[WORD_W-5:4];
endmodule

// File: rtl/dbg_cmd_port.sv
module dbg_cmd_port
    import dbg_port_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dbg_sclk,
    input  logic                dbg_sdi,
    output logic                dbg_sdo,
    input  logic                entry_req,
    input  logic [1:0]          entry_src,
    input  logic [WORD_W-1:0]   entry_ssw,
    input  logic [2*WORD_W-1:0] core_pc,
    output logic                dbg_active,
    output logic                seq_err,
    output logic [2*WORD_W-1:0] pc_o
);
    localparam int DATA_W  = 2 * WORD_W;
    localparam int FRAME_W = WORD_W + 1;
    localparam int BCNT_W  = $clog2(FRAME_W + 1);
    localparam logic [FRAME_W-1:0] NOTRDY = {1'b1, {WORD_W{1'b0}}};

    typedef struct packed {
        logic               active;
        logic               first;
        logic               seq_err;
        logic [BCNT_W-1:0]  bcnt;
        logic [WORD_W-1:0]  in_sh;
        logic [1:0]         wcnt;
        logic [WORD_W-1:0]  op;
        logic [WORD_W-1:0]  ext1;
        logic [FRAME_W-1:0] outf;
        logic               hold;
        logic               pend;
        logic [WORD_W-1:0]  lo;
        logic [DATA_W-1:0]  cause;
        logic [DATA_W-1:0]  pc;
    } port_st_t;

    port_st_t st_q, st_d;

    logic sclk_rise, sclk_fall, sdi_s;

    dbg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (dbg_sclk),
        .sdi_i  (dbg_sdi),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall),
        .sdi_o  (sdi_s)
    );

    logic [WORD_W-1:0] word_n, op_cur;
    logic [1:0]        ext_cnt;
    cmd_kind_e         kind;
    logic              sel_cause, sel_pc, cmd_done;
    logic [DATA_W-1:0] rd_val, wr_val;

    assign word_n = {st_q.in_sh[WORD_W-2:0], sdi_s};
    assign op_cur = (st_q.wcnt == 2'd0) ? word_n : st_q.op;

    dbg_cmd_decode #(.WORD_W(WORD_W)) u_dec (
        .op_i        (op_cur),
        .ext_cnt_o   (ext_cnt),
        .kind_o      (kind),
        .sel_cause_o (sel_cause),
        .sel_pc_o    (sel_pc)
    );

    always_comb begin
        st_d     = st_q;
        cmd_done = (st_q.wcnt == ext_cnt);
        rd_val   = sel_cause ? st_q.cause : (sel_pc ? st_q.pc : '0);
        case (ext_cnt)
            2'd2:    wr_val = {st_q.ext1, word_n};
            2'd1:    wr_val = {{WORD_W{1'b0}}, word_n};
            default: wr_val = '0;
        endcase

        if (entry_req) begin
            st_d.active  = 1'b1;
            st_d.first   = 1'b1;
            st_d.seq_err = 1'b0;
            st_d.bcnt    = '0;
            st_d.wcnt    = '0;
            st_d.pend    = 1'b0;
            st_d.hold    = 1'b0;
            st_d.outf    = NOTRDY;
            st_d.pc      = {core_pc[DATA_W-1:1], 1'b0};
            case (entry_src_e'(entry_src))
                SRC_HWBRK:  st_d.cause = '0;
                SRC_SWBRK:  st_d.cause = DATA_W'(1);
                SRC_DBLFLT: st_d.cause = {entry_ssw, {WORD_W{1'b1}}};
                default: begin
                    st_d.cause = {entry_ssw, {WORD_W{1'b1}}};
                    st_d.pc    = '1;
                end
            endcase
        end else if (st_q.active) begin
            if (sclk_fall) begin
                if (st_q.hold) st_d.hold = 1'b0;
                else           st_d.outf = {st_q.outf[FRAME_W-2:0], 1'b0};
            end
            if (sclk_rise) begin
                if (st_q.bcnt == '0) begin
                    st_d.bcnt = BCNT_W'(1);
                end else begin
                    st_d.in_sh = word_n;
                    if (st_q.bcnt == BCNT_W'(FRAME_W - 1)) begin
                        st_d.bcnt = '0;
                        st_d.hold = 1'b1;
                        // outgoing frame for the next transfer
                        if (st_q.pend) begin
                            st_d.outf = {1'b0, st_q.lo};
                            st_d.pend = 1'b0;
                        end else if (cmd_done && kind == K_RDREG) begin
                            st_d.outf = {1'b0, rd_val[DATA_W-1:WORD_W]};
                            st_d.lo   = rd_val[WORD_W-1:0];
                            st_d.pend = 1'b1;
                        end else begin
                            st_d.outf = NOTRDY;
                        end
                        if (!cmd_done) begin
                            st_d.wcnt = st_q.wcnt + 2'd1;
                            st_d.op   = op_cur;
                            if (st_q.wcnt == 2'd1) st_d.ext1 = word_n;
                        end else begin
                            st_d.wcnt  = '0;
                            st_d.first = 1'b0;
                            if (st_q.first && kind != K_RDREG) st_d.seq_err = 1'b1;
                            case (kind)
                                K_WRREG: begin
                                    if (sel_cause) st_d.cause = wr_val;
                                    if (sel_pc)    st_d.pc = {wr_val[DATA_W-1:1], 1'b0};
                                end
                                K_GO: begin
                                    st_d.active = 1'b0;
                                    st_d.pend   = 1'b0;
                                    st_d.outf   = NOTRDY;
                                end
                                default: ;
                            endcase
                        end
                    end else begin
                        st_d.bcnt = st_q.bcnt + BCNT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.outf <= NOTRDY;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_sdo    = st_q.outf[FRAME_W-1];
    assign dbg_active = st_q.active;
    assign seq_err    = st_q.seq_err;
    assign pc_o       = st_q.pc;
endmodule

// File: rtl/dbg_cmd_port_chk.sv
module dbg_cmd_port_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_sdo,
    input logic              dbg_active,
    input logic              seq_err,
    input logic              entry_req,
    input logic              sclk_rise,
    input logic              sclk_fall,
    input logic [DATA_W-1:0] pc_o
);
    a_r5_entry_activates: assert property (@(posedge clk) disable iff (!rst_n)
        entry_req |=> (dbg_active && dbg_sdo && !seq_err));

    a_r7_pc_odd_only_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[0] |-> (&pc_o));

    a_r10_idle_sdo_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_active && !entry_req) |=> $stable(dbg_sdo));

    a_r1_sdo_moves_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dbg_sdo) |-> $past(sclk_rise || sclk_fall || entry_req));

    a_r8_seq_err_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(sclk_rise));
endmodule

bind dbg_cmd_port dbg_cmd_port_chk #(.DATA_W(2 * WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_sdo    (dbg_sdo),
    .dbg_active (dbg_active),
    .seq_err    (seq_err),
    .entry_req  (entry_req),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .pc_o       (pc_o)
);

// File: tb/dbg_cmd_port_tb.sv
module dbg_cmd_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_sclk = 1'b0;
    logic        dbg_sdi = 1'b0;
    logic        dbg_sdo;
    logic        entry_req = 1'b0;
    logic [1:0]  entry_src = 2'd0;
    logic [15:0] entry_ssw = 16'h0;
    logic [31:0] core_pc = 32'h0;
    logic        dbg_active, seq_err;
    logic [31:0] pc_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dbg_cmd_port u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_sclk(dbg_sclk), .dbg_sdi(dbg_sdi),
        .dbg_sdo(dbg_sdo), .entry_req(entry_req), .entry_src(entry_src),
        .entry_ssw(entry_ssw), .core_pc(core_pc), .dbg_active(dbg_active),
        .seq_err(seq_err), .pc_o(pc_o)
    );

    // {word sent, 17-bit frame expected back during it}
    localparam int NV = 22;
    localparam logic [32:0] VEC [NV] = '{
        {16'h0000, 17'h10000}, {16'h3000, 17'h00000}, {16'h3000, 17'h00001},
        {16'h0001, 17'h10000}, {16'h3000, 17'h00000}, {16'h3000, 17'h01234},
        {16'h9001, 17'h10000}, {16'hABCD, 17'h10000}, {16'h5679, 17'h10000},
        {16'h0001, 17'h10000}, {16'h3000, 17'h0ABCD}, {16'h3000, 17'h05678},
        {16'hD000, 17'h10000}, {16'h1111, 17'h10000}, {16'h2222, 17'h10000},
        {16'h0000, 17'h10000}, {16'h3000, 17'h01111}, {16'h3000, 17'h02222},
        {16'h4001, 17'h10000}, {16'h0000, 17'h10000}, {16'h3000, 17'h0ABCD},
        {16'h3000, 17'h05678}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] w, output logic [16:0] rx);
        logic [16:0] f;
        f = {1'b0, w};
        for (int i = 16; i >= 0; i--) begin
            dbg_sdi = f[i];
            repeat (6) @(negedge clk);
            rx[i] = dbg_sdo;
            dbg_sclk = 1'b1;
            repeat (6) @(negedge clk);
            dbg_sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic enter(input logic [1:0] src, input logic [15:0] ssw, input logic [31:0] pc);
        @(negedge clk);
        entry_src = src; entry_ssw = ssw; core_pc = pc; entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        logic [16:0] rx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 active after reset", 32'(dbg_active), 32'd0);
        check("R11 seq_err after reset", 32'(seq_err), 32'd0);
        check("R11 sdo after reset", 32'(dbg_sdo), 32'd1);
        check("R11 pc after reset", pc_o, 32'h0);

        // R5/R6: software breakpoint entry, odd core PC cleared
        enter(2'd1, 16'h0, 32'h0000_1235);
        check("R5 active on entry", 32'(dbg_active), 32'd1);
        check("R6 pc even on entry", pc_o, 32'h0000_1234);
        // R1 R2 R3 R4 R9: table of frames
        for (int k = 0; k < NV; k++) begin
            xfer(VEC[k][32:17], rx);
            check($sformatf("R3 frame %0d", k), 32'(rx), 32'(VEC[k][16:0]));
        end
        check("R9 pc after write", pc_o, 32'hABCD_5678);
        check("R8 no seq_err after read first", 32'(seq_err), 32'd0);

        // R10: resume, then clocks are ignored
        xfer(16'h2000, rx);
        check("R10 resume frame", 32'(rx), 32'h10000);
        check("R10 inactive after resume", 32'(dbg_active), 32'd0);
        xfer(16'h0000, rx);
        check("R10 sdo held while idle", 32'(rx), 32'h1FFFF);
        check("R10 still inactive", 32'(dbg_active), 32'd0);

        // R8 + R5 hardware breakpoint code
        enter(2'd0, 16'h0, 32'h0000_0100);
        check("R8 cleared on entry", 32'(seq_err), 32'd0);
        xfer(16'h3000, rx);
        check("R8 no-op first sets flag", 32'(seq_err), 32'd1);
        xfer(16'h0000, rx);
        xfer(16'h3000, rx);
        check("R5 breakpoint hi", 32'(rx), 32'h00000);
        xfer(16'h3000, rx);
        check("R5 breakpoint lo", 32'(rx), 32'h00000);
        check("R8 flag sticky", 32'(seq_err), 32'd1);

        // R6 double fault
        enter(2'd2, 16'hA5C3, 32'h0000_2001);
        check("R8 cleared on re-entry", 32'(seq_err), 32'd0);
        check("R6 pc bit0 cleared", pc_o, 32'h0000_2000);
        xfer(16'h0000, rx);
        xfer(16'h3000, rx);
        check("R6 ssw in upper half", 32'(rx), 32'h0A5C3);
        xfer(16'h3000, rx);
        check("R6 lower half ones", 32'(rx), 32'h0FFFF);

        // R7 reset-fetch double fault
        enter(2'd3, 16'h1357, 32'h0000_0040);
        check("R7 pc all ones", pc_o, 32'hFFFF_FFFF);
        xfer(16'h0000, rx);
        xfer(16'h3000, rx);
        check("R7 ssw in upper half", 32'(rx), 32'h01357);
        xfer(16'h3000, rx);
        check("R7 lower half ones", 32'(rx), 32'h0FFFF);
        check("R8 read first no flag", 32'(seq_err), 32'd0);

        finish_run();
    end
endmodule